// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the device-side command front end of a serial NOR flash. It watches a chip-select-framed serial bus (clock, active-low select, four data lines), oversamples it in the device's own clock domain, and gathers the instruction byte and any address bytes that follow. It hands each accepted command to the rest of the device as a single-cycle strobe that carries the opcode, the address and the address width in force. Pad drivers, output data shifting, the memory array and double-rate or two-line read variants are handled elsewhere. The block only supplies `tx_shift`, a pulse on each falling clock edge inside a frame, so that an output shifter can launch its next bit.

The front end keeps three pieces of interface state. The first is the instruction width: single-line, or four-line nibble mode in which every phase moves four bits per clock. The second is the address width, 3 or 4 bytes. The third is a reset-enable latch that arms a two-step software reset. While the device reports an internal operation in progress (`busy`), a filter lets only a short list of opcodes through. These are the register status reads, the reset pair and program/erase suspend. Every other opcode is dropped without a trace.

The command output is a stream with a valid strobe and no ready. The serial host cannot be stalled, so a consumer must take `cmd_*` in the cycle `cmd_valid` is high. The data are not held for it afterwards.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After `rst_n` is released, `cmd_valid`, `sw_reset`, `qpi_mode` and `addr4_mode` are all 0, so the interface is in single-line mode with 3-byte addressing.
- R2: Data lines are sampled only on rising `sck` edges inside a frame. A frame decodes the same whether `sck` idles low or high. `tx_shift` pulses once for every falling `sck` edge inside a frame.
- R3: After reset no frame begins until `cs_n` has been seen high and then low. Clock edges while `cs_n` is high, or while `cs_n` has been held low since reset, produce no command and change no mode.
- R4: In single-line mode the 8 instruction bits and then the address bits arrive on `io_in[0]`, most significant bit first. `cmd_valid` pulses for exactly one cycle after the last address bit is sampled, or after the 8th instruction bit for an opcode without an address. Opcodes 03h, 0Bh, 02h, 32h, 38h, 20h, D7h, 52h and D8h take an address of the current width.
- R5: Opcode 35h sets `qpi_mode` and opcode F5h clears it. In `qpi_mode` instruction and address move 4 bits per edge on `io_in[3:0]`. `io_in[n]` carries bit n+4 of a byte on the first edge and bit n on the second, so the upper nibble comes first.
- R6: Opcode B7h sets `addr4_mode` and 29h clears it, which selects 32 or 24 address bits. Opcodes 13h, 0Ch, 12h, 34h, 3Eh, 21h, 5Ch and DCh always take 32 bits. `cmd_addr4` reports the width used, or the current mode for an opcode without an address.
- R7: A frame whose opcode is 99h performs a software reset only when the frame just before it delivered opcode 66h. The reset clears `qpi_mode` and `addr4_mode` and pulses `sw_reset` for one cycle. Any other intervening frame, including an aborted one, cancels the reset enable.
- R8: Asserting `rst_n` returns the interface to single-line mode with 3-byte addressing.
- R9: An opcode that completes while `busy` is high is ignored unless it is 05h, 48h, 81h, 66h, 99h, 75h or B0h. An ignored opcode produces no strobe and no mode change.
- R10: If `cs_n` rises before the instruction or address is complete, the frame produces no strobe and no mode change.
- R11: When `cmd_addr4` is 0, `cmd_addr[31:24]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, much faster than `sck` |
| rst_n | input | 1 | Active-low hardware reset |
| sck | input | 1 | Serial bus clock (idle low or high) |
| cs_n | input | 1 | Active-low frame select |
| io_in | input | 4 | Serial data lines; only bit 0 used in single-line mode |
| busy | input | 1 | Internal write/erase operation in progress |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 8 | Decoded opcode |
| cmd_addr | output | 32 | Captured address, right aligned |
| cmd_addr4 | output | 1 | Address width flag: 1 = 4 bytes |
| qpi_mode | output | 1 | Four-line instruction mode active |
| addr4_mode | output | 1 | 4-byte address mode active |
| sw_reset | output | 1 | One-cycle software reset pulse |
| tx_shift | output | 1 | Pulse per falling `sck` edge inside a frame |

## Verification
The case hardest to reach from the ports is the interaction between the reset-enable latch and the frame boundaries. A cancelled reset enable looks exactly like an honoured one until opcode 99h arrives, and a frame aborted after a few bits must count as the intervening frame. The bench reaches it with a 66h frame followed by aborted, ordinary and busy frames and then 99h, and it checks the modes and the reset pulse after each frame. A second hard case is the power-up rule. The bench holds `cs_n` low through reset release and clocks a full opcode in before `cs_n` ever goes high. A sweep over all 256 opcodes, idle and busy, in whatever mode the previous opcodes left the interface, covers the filter, the address widths and the nibble mode against a model computed in the bench.

// File: rtl/flashfe_pkg.sv
package flashfe_pkg;

  localparam int unsigned OPC_BITS   = 8;
  localparam int unsigned QUAD_LANES = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_OPC, PH_ADDR, PH_SKIP} phase_e;
  typedef enum logic [1:0] {AK_NONE, AK_MODE, AK_WIDE} addr_kind_e;

  localparam logic [7:0] OP_QPI_ENTER = 8'h35;
  localparam logic [7:0] OP_QPI_LEAVE = 8'hF5;
  localparam logic [7:0] OP_ADR4_ON   = 8'hB7;
  localparam logic [7:0] OP_ADR4_OFF  = 8'h29;
  localparam logic [7:0] OP_RST_ARM   = 8'h66;
  localparam logic [7:0] OP_RST_FIRE  = 8'h99;

  // Address phase attached to an opcode.
  function automatic addr_kind_e addr_kind(input logic [7:0] op);
    case (op)
      8'h03, 8'h0B, 8'h02, 8'h32, 8'h38,
      8'h20, 8'hD7, 8'h52, 8'hD8:         return AK_MODE;
      8'h13, 8'h0C, 8'h12, 8'h34, 8'h3E,
      8'h21, 8'h5C, 8'hDC:                return AK_WIDE;
      default:                            return AK_NONE;
    endcase
  endfunction

  // Opcodes that still pass while an internal operation runs.
  function automatic logic pass_when_busy(input logic [7:0] op);
    case (op)
      8'h05, 8'h48, 8'h81, 8'h66, 8'h99, 8'h75, 8'hB0: return 1'b1;
      default:                                         return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/flashfe_sync.sv
module flashfe_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/flashfe_edges.sv
module flashfe_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_n_s,
  output logic frame_start,
  output logic frame_end,
  output logic sample,
  output logic launch
);
  logic sck_d, cs_d, in_frame;

  // cs_d resets to the selected level, so a select held low through reset
  // never looks like a falling edge.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_d    <= 1'b0;
      cs_d     <= 1'b0;
      in_frame <= 1'b0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_n_s;
      if (frame_start)  in_frame <= 1'b1;
      else if (cs_n_s)  in_frame <= 1'b0;
    end

  assign frame_start = !cs_n_s && cs_d;
  assign frame_end   = in_frame && cs_n_s;
  assign sample      = in_frame && !cs_n_s && sck_s && !sck_d;
  assign launch      = in_frame && !cs_n_s && !sck_s && sck_d;
endmodule

// File: rtl/flashfe_capture.sv
module flashfe_capture
  import flashfe_pkg::*;
#(
  parameter int unsigned ADDR_BYTES_WIDE   = 4,
  parameter int unsigned ADDR_BYTES_NARROW = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_start,
  input  logic                         frame_end,
  input  logic                         sample,
  input  logic [QUAD_LANES-1:0]        io,
  input  logic                         qpi,
  input  logic                         addr4,
  input  logic                         busy,
  output logic                         cmd_valid,
  output logic [OPC_BITS-1:0]          cmd_op,
  output logic [8*ADDR_BYTES_WIDE-1:0] cmd_addr,
  output logic                         cmd_addr4
);
  localparam int unsigned ADDR_W = 8 * ADDR_BYTES_WIDE;
  localparam int unsigned CNT_W  = $clog2(ADDR_W + 1);
  localparam logic [CNT_W-1:0] WIDE_BITS   = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] NARROW_BITS = CNT_W'(8 * ADDR_BYTES_NARROW);
  localparam logic [CNT_W-1:0] OPC_CNT     = CNT_W'(OPC_BITS);

  phase_e              phase;
  logic [CNT_W-1:0]    cnt, cnt_next, step, abits_q, abits_now;
  logic [ADDR_W-1:0]   sh, sh_next;
  logic [OPC_BITS-1:0] op_q, op_now;
  addr_kind_e          kind_now;
  logic                take_now;

  always_comb begin
    step      = qpi ? CNT_W'(QUAD_LANES) : CNT_W'(1);
    cnt_next  = cnt + step;
    sh_next   = qpi ? {sh[ADDR_W-QUAD_LANES-1:0], io} : {sh[ADDR_W-2:0], io[0]};
    op_now    = sh_next[OPC_BITS-1:0];
    kind_now  = addr_kind(op_now);
    take_now  = !busy || pass_when_busy(op_now);
    if (kind_now == AK_NONE)                     abits_now = '0;
    else if (kind_now == AK_WIDE || addr4)       abits_now = WIDE_BITS;
    else                                         abits_now = NARROW_BITS;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      sh        <= '0;
      op_q      <= '0;
      abits_q   <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_addr  <= '0;
      cmd_addr4 <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (frame_start) begin
        phase <= PH_OPC;
        cnt   <= '0;
        sh    <= '0;
      end else if (frame_end) begin
        phase <= PH_IDLE;
      end else if (sample) begin
        case (phase)
          PH_OPC: begin
            if (cnt_next == OPC_CNT) begin
              if (!take_now) begin
                phase <= PH_SKIP;
              end else if (abits_now == '0) begin
                cmd_valid <= 1'b1;
                cmd_op    <= op_now;
                cmd_addr  <= '0;
                cmd_addr4 <= addr4;
                phase     <= PH_SKIP;
              end else begin
                op_q    <= op_now;
                abits_q <= abits_now;
                cnt     <= '0;
                sh      <= '0;
                phase   <= PH_ADDR;
              end
            end else begin
              cnt <= cnt_next;
              sh  <= sh_next;
            end
          end
          PH_ADDR: begin
            if (cnt_next == abits_q) begin
              cmd_valid <= 1'b1;
              cmd_op    <= op_q;
              cmd_addr  <= sh_next;
              cmd_addr4 <= (abits_q == WIDE_BITS);
              phase     <= PH_SKIP;
            end else begin
              cnt <= cnt_next;
              sh  <= sh_next;
            end
          end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/flashfe_modes.sv
module flashfe_modes
  import flashfe_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [OPC_BITS-1:0] cmd_op,
  input  logic                frame_end,
  output logic                qpi,
  output logic                addr4,
  output logic                sw_reset
);
  logic arm_now, armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      qpi      <= 1'b0;
      addr4    <= 1'b0;
      arm_now  <= 1'b0;
      armed    <= 1'b0;
      sw_reset <= 1'b0;
    end else begin
      sw_reset <= 1'b0;
      if (cmd_valid) begin
        case (cmd_op)
          OP_QPI_ENTER: qpi     <= 1'b1;
          OP_QPI_LEAVE: qpi     <= 1'b0;
          OP_ADR4_ON:   addr4   <= 1'b1;
          OP_ADR4_OFF:  addr4   <= 1'b0;
          OP_RST_ARM:   arm_now <= 1'b1;
          OP_RST_FIRE:
            if (armed) begin
              qpi      <= 1'b0;
              addr4    <= 1'b0;
              sw_reset <= 1'b1;
              armed    <= 1'b0;
            end
          default: ;
        endcase
      end
      // The enable survives exactly one frame boundary.
      if (frame_end) begin
        armed   <= arm_now;
        arm_now <= 1'b0;
      end
    end
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import flashfe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES       = 2,
  parameter int unsigned ADDR_BYTES_WIDE   = 4,
  parameter int unsigned ADDR_BYTES_NARROW = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sck,
  input  logic                         cs_n,
  input  logic [QUAD_LANES-1:0]        io_in,
  input  logic                         busy,
  output logic                         cmd_valid,
  output logic [OPC_BITS-1:0]          cmd_op,
  output logic [8*ADDR_BYTES_WIDE-1:0] cmd_addr,
  output logic                         cmd_addr4,
  output logic                         qpi_mode,
  output logic                         addr4_mode,
  output logic                         sw_reset,
  output logic                         tx_shift
);
  localparam int unsigned SYNC_W = QUAD_LANES + 2;

  logic [SYNC_W-1:0]     raw_bus, sync_bus;
  logic                  sck_s, cs_n_s;
  logic [QUAD_LANES-1:0] io_s;
  logic                  f_start, f_end, f_sample;

  assign raw_bus = {cs_n, sck, io_in};
  assign {cs_n_s, sck_s, io_s} = sync_bus;

  flashfe_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus));

  flashfe_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s),
    .frame_start(f_start), .frame_end(f_end), .sample(f_sample), .launch(tx_shift));

  flashfe_capture #(
    .ADDR_BYTES_WIDE(ADDR_BYTES_WIDE), .ADDR_BYTES_NARROW(ADDR_BYTES_NARROW)
  ) u_capture (
    .clk(clk), .rst_n(rst_n), .frame_start(f_start), .frame_end(f_end),
    .sample(f_sample), .io(io_s), .qpi(qpi_mode), .addr4(addr4_mode), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_addr4(cmd_addr4));

  flashfe_modes u_modes (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .frame_end(f_end), .qpi(qpi_mode), .addr4(addr4_mode), .sw_reset(sw_reset));
endmodule

// File: rtl/flashfe_checker.sv
module flashfe_checker
  import flashfe_pkg::*;
#(
  parameter int unsigned ADDR_BYTES_WIDE   = 4,
  parameter int unsigned ADDR_BYTES_NARROW = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         busy,
  input logic                         cmd_valid,
  input logic [OPC_BITS-1:0]          cmd_op,
  input logic [8*ADDR_BYTES_WIDE-1:0] cmd_addr,
  input logic                         cmd_addr4,
  input logic                         qpi_mode,
  input logic                         addr4_mode,
  input logic                         sw_reset
);
  localparam int unsigned NARROW_BITS = 8 * ADDR_BYTES_NARROW;

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_busy_filter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (!$past(busy) || pass_when_busy(cmd_op)));

  assert_qpi_enter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qpi_mode) |-> ($past(cmd_valid) && $past(cmd_op) == OP_QPI_ENTER));

  assert_qpi_leave_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(qpi_mode) |-> ($past(cmd_valid) &&
                         ($past(cmd_op) == OP_QPI_LEAVE || sw_reset)));

  assert_addr4_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr4_mode) |-> ($past(cmd_valid) && $past(cmd_op) == OP_ADR4_ON));

  assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |-> (!qpi_mode && !addr4_mode && $past(cmd_valid) &&
                  $past(cmd_op) == OP_RST_FIRE));

  assert_narrow_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_addr4) |-> ((cmd_addr >> NARROW_BITS) == '0));
endmodule

bind flash_cmd_frontend flashfe_checker #(
  .ADDR_BYTES_WIDE(ADDR_BYTES_WIDE), .ADDR_BYTES_NARROW(ADDR_BYTES_NARROW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_addr(cmd_addr), .cmd_addr4(cmd_addr4), .qpi_mode(qpi_mode),
  .addr4_mode(addr4_mode), .sw_reset(sw_reset));

// File: tb/tb_flash_cmd_frontend.sv
`timescale 1ns/1ps
module tb_flash_cmd_frontend;
  logic        clk = 1'b0;
  logic        rst_n, sck, cs_n, busy;
  logic [3:0]  io_in;
  logic        cmd_valid, cmd_addr4, qpi_mode, addr4_mode, sw_reset, tx_shift;
  logic [7:0]  cmd_op;
  logic [31:0] cmd_addr;

  always #2.5 clk = ~clk;

  flash_cmd_frontend dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_in(io_in), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_addr4(cmd_addr4),
    .qpi_mode(qpi_mode), .addr4_mode(addr4_mode), .sw_reset(sw_reset), .tx_shift(tx_shift));

  int n_chk = 0, n_bad = 0;
  int vcnt = 0, srcnt = 0, txcnt = 0, dbl = 0;
  logic        prev_v = 1'b0;
  logic [7:0]  l_op;
  logic [31:0] l_addr;
  logic        l_a4;

  // Output monitor, sampling away from the active edge.
  always @(negedge clk) begin
    if (cmd_valid) begin
      vcnt++;
      l_op   = cmd_op;
      l_addr = cmd_addr;
      l_a4   = cmd_addr4;
      if (prev_v) dbl++;
    end
    prev_v = cmd_valid;
    if (sw_reset) srcnt++;
    if (tx_shift) txcnt++;
  end

  // Bench-side model of the interface state.
  logic m_qpi = 1'b0, m_a4 = 1'b0, m_arm = 1'b0;

  function automatic int b_kind(input logic [7:0] op);
    if (op inside {8'h13, 8'h0C, 8'h12, 8'h34, 8'h3E, 8'h21, 8'h5C, 8'hDC}) return 2;
    if (op inside {8'h02, 8'h03, 8'h0B, 8'h20, 8'h32, 8'h38, 8'h52, 8'hD7, 8'hD8}) return 1;
    return 0;
  endfunction

  function automatic logic b_pass(input logic [7:0] op);
    return op inside {8'h05, 8'h48, 8'h66, 8'h75, 8'h81, 8'h99, 8'hB0};
  endfunction

  function automatic logic [3:0] lane_val(input logic [7:0] op, input logic [31:0] addr,
                                          input int abits, input int lanes, input int e);
    if (lanes == 1) begin
      if (e < 8) return {3'b000, op[7-e]};
      return {3'b000, addr[abits-1-(e-8)]};
    end
    if (e == 0) return op[7:4];
    if (e == 1) return op[3:0];
    return addr[abits-4-4*(e-2) +: 4];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One chip-select frame; abort_at >= 0 raises cs after that many rising edges.
  task automatic do_frame(input logic [7:0] op, input logic [31:0] addr, input logic bsy,
                          input logic m3, input int abort_at, input string tag);
    int lanes, kind, abits, total, sent, v0, s0, t0;
    logic acc, exp_v, exp_a4, exp_sw;
    logic [31:0] mask;
    lanes = m_qpi ? 4 : 1;
    kind  = b_kind(op);
    abits = (kind == 0) ? 0 : ((kind == 2 || m_a4) ? 32 : 24);
    total = 8 / lanes + abits / lanes;
    mask  = (abits == 32) ? 32'hFFFF_FFFF : ((abits == 24) ? 32'h00FF_FFFF : 32'h0);
    acc   = !bsy || b_pass(op);
    exp_v = acc && (abort_at < 0);
    exp_a4 = (kind == 0) ? m_a4 : (abits == 32);
    v0 = vcnt; s0 = srcnt; t0 = txcnt; sent = 0;
    busy = bsy; sck = m3;
    tick(2);
    cs_n = 1'b0;
    tick(3);
    for (int e = 0; e < total; e++) begin
      if (abort_at >= 0 && e == abort_at) break;
      sck = 1'b0;
      io_in = lane_val(op, addr, abits, lanes, e);
      tick(2);
      sck = 1'b1;
      tick(2);
      sent++;
    end
    if (!m3) sck = 1'b0;
    tick(2);
    cs_n = 1'b1;
    tick(8);
    busy = 1'b0;
    // Model update.
    exp_sw = 1'b0;
    if (exp_v) begin
      case (op)
        8'h35: m_qpi = 1'b1;
        8'hF5: m_qpi = 1'b0;
        8'hB7: m_a4  = 1'b1;
        8'h29: m_a4  = 1'b0;
        8'h99: if (m_arm) begin m_qpi = 1'b0; m_a4 = 1'b0; exp_sw = 1'b1; end
        default: ;
      endcase
    end
    m_arm = exp_v && (op == 8'h66);
    chk(tag, "strobe count", vcnt - v0, {31'd0, exp_v});
    if (exp_v) begin
      chk(tag, "opcode", {24'd0, l_op}, {24'd0, op});
      chk(tag, "address", l_addr, addr & mask);
      chk(tag, "address width flag", {31'd0, l_a4}, {31'd0, exp_a4});
      if (!exp_a4) chk("R11", "upper address byte", {24'd0, l_addr[31:24]}, 32'd0);
    end
    chk("R5", "qpi_mode after frame", {31'd0, qpi_mode}, {31'd0, m_qpi});
    chk("R6", "addr4_mode after frame", {31'd0, addr4_mode}, {31'd0, m_a4});
    chk("R7", "sw_reset pulses", srcnt - s0, {31'd0, exp_sw});
    chk("R2", "tx_shift pulses", txcnt - t0, sent);
  endtask

  // Eight single-line edges with cs_n left as it is.
  task automatic raw_edges(input logic [7:0] op);
    for (int e = 0; e < 8; e++) begin
      sck = 1'b0;
      io_in = {3'b000, op[7-e]};
      tick(2);
      sck = 1'b1;
      tick(2);
    end
    sck = 1'b0;
    tick(8);
  endtask

  task automatic hw_reset(input logic cs_level);
    rst_n = 1'b0; cs_n = cs_level; sck = 1'b0; io_in = '0; busy = 1'b0;
    tick(5);
    rst_n = 1'b1;
    m_qpi = 1'b0; m_a4 = 1'b0; m_arm = 1'b0;
    tick(3);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
    $finish;
  end

  initial begin
    int v0;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; io_in = '0; busy = 1'b0;

    // R1: reset state.
    hw_reset(1'b1);
    chk("R1", "cmd_valid", {31'd0, cmd_valid}, 32'd0);
    chk("R1", "qpi_mode", {31'd0, qpi_mode}, 32'd0);
    chk("R1", "addr4_mode", {31'd0, addr4_mode}, 32'd0);
    chk("R1", "sw_reset", {31'd0, sw_reset}, 32'd0);

    // R3: select held low since reset, then clocks with select high.
    hw_reset(1'b0);
    v0 = vcnt;
    raw_edges(8'hB7);
    chk("R3", "strobes with cs low since reset", vcnt - v0, 32'd0);
    chk("R3", "addr4_mode unchanged", {31'd0, addr4_mode}, 32'd0);
    cs_n = 1'b1;
    tick(4);
    raw_edges(8'h35);
    chk("R3", "strobes with cs high", vcnt - v0, 32'd0);
    chk("R3", "qpi_mode unchanged", {31'd0, qpi_mode}, 32'd0);
    do_frame(8'h05, 32'h0, 1'b0, 1'b0, -1, "R3");

    // R2: idle-high clock, single-line read with address.
    do_frame(8'h03, 32'h0012_3456, 1'b0, 1'b1, -1, "R2");
    do_frame(8'h0C, 32'hA5C3_0F81, 1'b0, 1'b1, -1, "R2");

    // R10: aborted instruction and aborted address.
    do_frame(8'h35, 32'h0, 1'b0, 1'b0, 5, "R10");
    do_frame(8'h03, 32'h00AB_CDEF, 1'b0, 1'b0, 18, "R10");
    do_frame(8'h05, 32'h0, 1'b0, 1'b0, -1, "R10");

    // R5, R6, R7: enter both modes, then honoured and cancelled resets.
    do_frame(8'h35, 32'h0, 1'b0, 1'b0, -1, "R5");
    do_frame(8'h03, 32'h00F0_E1D2, 1'b0, 1'b0, -1, "R5");
    do_frame(8'hB7, 32'h0, 1'b0, 1'b1, -1, "R6");
    do_frame(8'h0B, 32'h8765_4321, 1'b0, 1'b0, -1, "R6");
    do_frame(8'h66, 32'h0, 1'b0, 1'b0, -1, "R7");
    do_frame(8'h99, 32'h0, 1'b0, 1'b0, -1, "R7");
    do_frame(8'h35, 32'h0, 1'b0, 1'b0, -1, "R7");
    do_frame(8'h66, 32'h0, 1'b0, 1'b0, -1, "R7");
    do_frame(8'h05, 32'h0, 1'b0, 1'b0, -1, "R7");
    do_frame(8'h99, 32'h0, 1'b0, 1'b0, -1, "R7");
    do_frame(8'h66, 32'h0, 1'b1, 1'b0, -1, "R7");
    do_frame(8'h99, 32'h0, 1'b0, 1'b0, 1, "R7");
    do_frame(8'h99, 32'h0, 1'b0, 1'b0, -1, "R7");
    do_frame(8'h66, 32'h0, 1'b0, 1'b0, -1, "R7");
    do_frame(8'h99, 32'h0, 1'b1, 1'b0, -1, "R7");

    // R8: hardware reset leaves both modes.
    do_frame(8'h35, 32'h0, 1'b0, 1'b0, -1, "R8");
    do_frame(8'hB7, 32'h0, 1'b0, 1'b0, -1, "R8");
    hw_reset(1'b1);
    chk("R8", "qpi_mode after hardware reset", {31'd0, qpi_mode}, 32'd0);
    chk("R8", "addr4_mode after hardware reset", {31'd0, addr4_mode}, 32'd0);

    // R4, R5, R6, R9: every opcode, idle then busy, in the modes it leaves.
    for (int op = 0; op < 256; op++) begin
      for (int b = 0; b < 2; b++) begin
        logic [31:0] a;
        string tag;
        a = (op * 32'h0101_0101) ^ 32'h5A3C_96E1 ^ (b * 32'h1357_9BDF);
        if (b == 1)                       tag = "R9";
        else if (m_qpi)                   tag = "R5";
        else if (b_kind(8'(op)) == 2)     tag = "R6";
        else                              tag = "R4";
        do_frame(8'(op), a, b[0], 1'b0, -1, tag);
      end
    end

    chk("R4", "back-to-back strobe cycles", dbl, 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule